// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block runs after a translation miss. It takes a 64-bit virtual address and a root table base, and follows a four-level hierarchy of page tables in memory. At each level it forms an entry address from the current table base and a 9-bit slice of the virtual address. It issues one read for that entry and uses the returned entry either as the base of the next table or, at the last level, as the physical frame number. The final physical address is that frame joined to the untranslated 12-bit page offset.

Two conditions end a walk early with a fault. The first is a virtual address outside the canonical range, which is caught before any memory read. The second is a fetched entry whose present bit is clear; the fault then reports the level where the walk stopped. The walker takes one request at a time. It keeps at most one table read in flight and holds its request side not-ready until the result has been delivered.

The controller has four states. IDLE accepts a request. ISSUE drives a single-cycle table read. WAIT holds until the read data returns. DONE presents the result for one cycle. The transitions are:
- IDLE to ISSUE on a canonical request.
- IDLE to DONE on a non-canonical request.
- ISSUE to WAIT always.
- WAIT to ISSUE when a present entry is not the leaf.
- WAIT to DONE on a leaf entry or a non-present entry.
- DONE to IDLE always.

Top module: `page_walker`

## Requirements
- R1: The virtual address fields are:
  - page offset in bits 11:0;
  - leaf-table index in bits 20:12;
  - directory index in bits 29:21;
  - directory-pointer index in bits 38:30;
  - top-level index in bits 47:39.
- R2: If bits 63:47 of the accepted address are not all equal, the cycle after acceptance shows `res_valid`=1, `res_fault`=1 and `res_noncanon`=1. No memory read is issued for that request.
- R3: The first read of a walk appears the cycle after acceptance. Its address is `{12'b0, root_base[51:12], 12'b0}` plus the top-level index times 8.
- R4: Each later read has the address `{12'b0, entry[51:12], 12'b0}` plus the next level's index times 8, where `entry` is the previous response. The levels are read in the order top, directory-pointer, directory, leaf.
- R5: A response with bit 0 clear ends the walk with `res_fault`=1 and `res_noncanon`=0. `res_level` then names the level that was read: 3 for top, 2 for directory-pointer, 1 for directory, 0 for leaf. No further read follows.
- R6: A present leaf entry yields `res_fault`=0 and `res_paddr` = `{12'b0, leaf[51:12], va[11:0]}`.
- R7: `mem_req_valid` is a single-cycle pulse. No new read is issued until a response to the previous one has arrived.
- R8: `req_ready` is 1 only when idle. It is 0 from the cycle after acceptance up to and including the result cycle. `res_valid` lasts exactly one cycle and is followed by `req_ready`=1.
- R9: A response arriving while no read is outstanding has no effect.
- R10: The result appears in the cycle after the response that completes the walk. The next read appears in the cycle after a response that continues the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| root_base | input | 64 | Root table base; bits 51:12 are used |
| mem_req_valid | output | 1 | Table entry read strobe |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Fetched table entry |
| res_valid | output | 1 | Result strobe |
| res_paddr | output | 64 | Physical address on success |
| res_fault | output | 1 | Walk ended in a fault |
| res_noncanon | output | 1 | Fault was a non-canonical address |
| res_level | output | 2 | Level at which a present-bit fault occurred |

## Verification
The bench sweeps many addresses whose four index fields take varied values, with both signs of bit 47. This separates a wrong field slice or a swapped level order from a correct walk, because every read address is predicted.

Each walk injects a present-bit fault at one chosen level, or none, and varies the response latency from zero to two cycles. This separates the fault levels from each other and checks that no extra read follows a fault.

Single-bit flips of each of bits 63:47 exercise the canonical check. Entries and roots carry non-zero bits outside 51:12 to expose missing masking. Stray responses in idle show that unsolicited data is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_DONE  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
    parameter int VA_W   = 64,
    parameter int IMPL_W = 48
) (
    input  logic [VA_W-1:IMPL_W-1] upper_bits,
    output logic                   is_canon
);
    // The sign bit and everything above it must agree.
    assign is_canon = (&upper_bits) | ~(|upper_bits);
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W      = 64,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int ENTRY_BYTES = 8,
    localparam int LVL_W      = $clog2(LEVELS),
    localparam int IDX_SPAN   = LEVELS * IDX_W,
    localparam int ENTRY_SH   = $clog2(ENTRY_BYTES)
) (
    input  logic [IDX_SPAN-1:0] idx_field,
    input  logic [ADDR_W-1:0]   table_base,
    input  logic [LVL_W-1:0]    level,
    output logic [ADDR_W-1:0]   entry_addr
);
    logic [IDX_W-1:0] idx_arr [LEVELS];

    // Level 0 is the leaf table and takes the lowest slice.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_arr[g] = idx_field[g*IDX_W +: IDX_W];
    end

    assign entry_addr = table_base + (ADDR_W'(idx_arr[level]) << ENTRY_SH);
endmodule

// File: rtl/page_walker.sv
module page_walker #(
    parameter int VA_W        = 64,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int FRAME_HI    = 51,
    parameter int ENTRY_BYTES = 8,
    localparam int IMPL_W     = OFF_W + LEVELS * IDX_W,
    localparam int LVL_W      = $clog2(LEVELS),
    localparam int FRAME_W    = FRAME_HI - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   root_base,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              res_valid,
    output logic [VA_W-1:0]   res_paddr,
    output logic              res_fault,
    output logic              res_noncanon,
    output logic [LVL_W-1:0]  res_level
);
    import ptw_pkg::*;

    walk_state_t          state_q, state_d;
    logic [IMPL_W-1:0]    va_q;
    logic [VA_W-1:0]      base_q;
    logic [LVL_W-1:0]     lvl_q;
    logic                 canon_ok;
    logic                 accept;
    logic                 entry_present;
    logic                 at_leaf;
    logic [VA_W-1:0]      rsp_frame_base;
    logic [VA_W-1:0]      root_frame_base;
    logic                 unused_bits;

    assign accept        = req_valid && (state_q == W_IDLE);
    assign entry_present = mem_rsp_data[0];
    assign at_leaf       = (lvl_q == '0);

    assign rsp_frame_base  = VA_W'(mem_rsp_data[FRAME_HI:OFF_W]) << OFF_W;
    assign root_frame_base = VA_W'(root_base[FRAME_HI:OFF_W]) << OFF_W;
    assign unused_bits = ^{mem_rsp_data[VA_W-1:FRAME_HI+1], mem_rsp_data[OFF_W-1:1],
                           root_base[VA_W-1:FRAME_HI+1], root_base[OFF_W-1:0]};

    ptw_canon #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_canon (
        .upper_bits (req_vaddr[VA_W-1:IMPL_W-1]),
        .is_canon   (canon_ok)
    );

    ptw_entry_addr #(
        .ADDR_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_addr (
        .idx_field  (va_q[IMPL_W-1:OFF_W]),
        .table_base (base_q),
        .level      (lvl_q),
        .entry_addr (mem_req_addr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (accept) state_d = canon_ok ? W_ISSUE : W_DONE;
            W_ISSUE: state_d = W_WAIT;
            W_WAIT:  if (mem_rsp_valid)
                         state_d = (!entry_present || at_leaf) ? W_DONE : W_ISSUE;
            W_DONE:  state_d = W_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q         <= '0;
            base_q       <= '0;
            lvl_q        <= '0;
            res_paddr    <= '0;
            res_fault    <= 1'b0;
            res_noncanon <= 1'b0;
            res_level    <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: if (accept) begin
                    va_q         <= req_vaddr[IMPL_W-1:0];
                    base_q       <= root_frame_base;
                    lvl_q        <= LVL_W'(LEVELS - 1);
                    res_paddr    <= '0;
                    res_fault    <= !canon_ok;
                    res_noncanon <= !canon_ok;
                    res_level    <= '0;
                end
                W_WAIT: if (mem_rsp_valid) begin
                    if (!entry_present) begin
                        res_fault <= 1'b1;
                        res_level <= lvl_q;
                    end else if (at_leaf) begin
                        res_paddr <= rsp_frame_base | VA_W'(va_q[OFF_W-1:0]);
                    end else begin
                        base_q <= rsp_frame_base;
                        lvl_q  <= lvl_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready     = (state_q == W_IDLE);
    assign mem_req_valid = (state_q == W_ISSUE);
    assign res_valid     = (state_q == W_DONE);

    a_r2_noncanon_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !canon_ok) |=> (res_valid && res_fault && res_noncanon && !mem_req_valid));

    a_r3_canon_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && canon_ok) |=> (mem_req_valid && !res_valid));

    a_r4_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[$clog2(ENTRY_BYTES)-1:0] == '0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && (res_valid || req_ready)));

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    a_r5_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_noncanon) |-> res_fault);

    a_r9_idle_rsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> (req_ready && !res_valid && !mem_req_valid));
endmodule

// File: tb/page_walker_test.sv
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] root_base = '0;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [63:0] res_paddr;
    logic        res_fault;
    logic        res_noncanon;
    logic [1:0]  res_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault),
        .res_noncanon(res_noncanon), .res_level(res_level)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Table entry content as a function of its address.
    function automatic logic [39:0] frame_of(input logic [63:0] a);
        return (a[39:0] ^ 40'hA5_C35A_5A3C) * 40'd40503 + 40'd977;
    endfunction

    function automatic logic [63:0] entry_of(input logic [63:0] a, input bit present);
        return {12'hABC, frame_of(a), 11'h3F5, present};
    endfunction

    function automatic bit is_canon(input logic [63:0] v);
        return (v[63:47] == '0) || (v[63:47] == '1);
    endfunction

    // fail_lvl: 3..0 clears the present bit at that level, 4 = no fault
    task automatic walk(input logic [63:0] va, input logic [39:0] root_frame,
                        input int fail_lvl, input int lat);
        logic [63:0] base;
        logic [63:0] exp_addr;
        logic [63:0] ent;
        bit stopped;
        base = {12'b0, root_frame, 12'b0};
        stopped = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = {12'h5E1, root_frame, 12'h9A7};
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va;
        chk(req_ready == 1'b0, "R8 busy after accept", 64'(req_ready), 64'd0);
        if (!is_canon(va)) begin
            chk(res_valid && res_fault && res_noncanon && !mem_req_valid,
                "R2 noncanonical fault, no read",
                {res_valid, res_fault, res_noncanon, mem_req_valid}, 64'hE);
        end else begin
            for (int lvl = 3; lvl >= 0; lvl--) begin
                // R1 field slicing and R4 level order
                exp_addr = base + 64'(va[12 + lvl*9 +: 9]) * 8;
                chk(mem_req_valid == 1'b1, "R10 read issued", 64'(mem_req_valid), 64'd1);
                chk(mem_req_addr == exp_addr, (lvl == 3) ? "R3 first read address" : "R4 next read address",
                    mem_req_addr, exp_addr);
                @(negedge clk);
                chk(mem_req_valid == 1'b0, "R7 read is one cycle", 64'(mem_req_valid), 64'd0);
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    chk(mem_req_valid == 1'b0 && res_valid == 1'b0, "R7 waits for response",
                        {mem_req_valid, res_valid}, 64'd0);
                end
                ent = entry_of(exp_addr, lvl != fail_lvl);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ent;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
                if (lvl == fail_lvl) begin
                    chk(res_valid && res_fault && !res_noncanon && res_level == 2'(lvl) && !mem_req_valid,
                        "R5 present fault at level",
                        {res_valid, res_fault, res_noncanon, mem_req_valid, 2'b00, res_level},
                        {4'b1100, 2'b00, 2'(lvl)});
                    stopped = 1'b1;
                    break;
                end
                base = {12'b0, ent[51:12], 12'b0};
            end
            if (!stopped) begin
                exp_addr = {12'b0, frame_of(mem_req_addr_last(va, root_frame)), va[11:0]};
                chk(res_valid && !res_fault, "R10 result after leaf", {res_valid, res_fault}, 64'h2);
                chk(res_paddr == exp_addr, "R6 physical address", res_paddr, exp_addr);
            end
        end
        @(negedge clk);
        chk(res_valid == 1'b0 && req_ready == 1'b1, "R8 result one cycle then idle",
            {res_valid, req_ready}, 64'h1);
    endtask

    // Leaf entry address, from the requirements alone.
    function automatic logic [63:0] mem_req_addr_last(input logic [63:0] va, input logic [39:0] rf);
        logic [63:0] b;
        logic [63:0] a;
        b = {12'b0, rf, 12'b0};
        a = '0;
        for (int l = 3; l >= 0; l--) begin
            a = b + 64'(va[12 + l*9 +: 9]) * 8;
            b = {12'b0, frame_of(a), 12'b0};
        end
        return a;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_req_valid == 1'b0, "R8 reset state",
            {req_ready, res_valid, mem_req_valid}, 64'h4);
        rst_n = 1'b1;

        // R9: unsolicited responses while idle
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 64'h1 | (64'(k) << 20);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(req_ready && !res_valid && !mem_req_valid, "R9 stray response ignored",
                {req_ready, res_valid, mem_req_valid}, 64'h4);
        end

        // Index and sign sweep with faults and latencies (R1, R3-R7, R10)
        for (int i = 0; i < 120; i++) begin
            logic [47:0] low;
            logic [8:0] i3, i2, i1, i0;
            i3 = 9'((i * 61 + (i % 2) * 256) % 512);
            i2 = 9'((i * 29 + 7) % 512);
            i1 = 9'((i * 113 + 300) % 512);
            i0 = 9'((i * 7 + 511) % 512);
            low = {i3, i2, i1, i0, 12'((i * 331) % 4096)};
            walk({{16{low[47]}}, low}, 40'h12_3450_0000 + 40'(i * 4099), i % 5, i % 3);
        end

        // R2: flip each bit of 63:47 in canonical addresses of both signs
        for (int b = 47; b < 64; b++) begin
            walk(64'h0000_3F12_3456_789A ^ (64'd1 << b), 40'h77, 4, 0);
            walk(64'hFFFF_C0AB_CDEF_0123 ^ (64'd1 << b), 40'h88, 4, 0);
        end

        // R9 again after walks: stray response then a normal walk
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFE;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        walk(64'hFFFF_FFFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 4, 1);
        walk(64'h0000_0000_0000_0000, 40'h0, 4, 2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule